// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a complete serial EEPROM device as synthesizable logic. It has a three-wire command port (chip select, serial clock, data in), a tri-stated data-out, and an internal word array. The three command inputs are brought into the system clock domain through synchronizers. Each rising edge of the serial clock shifts in one bit of a command: a start bit, a two-bit opcode, an address, and, for writes, the data. Read data is shifted back out, one bit per serial-clock edge. The block can also show a ready/busy status on the data-out line while a programming cycle runs.

Programming is locked after reset. The host must send an unlock command before any write or erase can change the array. A programming command is launched when chip select falls after the command was complete. Its duration is modelled by a cycle counter. Bulk commands step through every word, one word per system clock.

A static organisation input selects one of two word sizes. When high, the array is seen as 16-bit words. When low, it is seen as bytes.

Top module: `mw_eeprom`

## Requirements
- R1: A command begins only on the first serial-clock rising edge at which chip select and data-in are both high; earlier edges with data-in low, and all activity with chip select low, start nothing.
- R2: The two bits after the start bit are the opcode: 10 read, 01 write, 11 erase. Opcode 00 is decoded by the two most significant address bits: 11 unlock, 00 lock, 10 erase-all, 01 write-all (followed by one data word).
- R3: With org high, the address is 10 bits and words are 16 bits. With org low, the address is 11 bits and words are 8 bits. Byte address b maps to the high half of 16-bit word b>>1 when b[0]=1 and to the low half when b[0]=0.
- R4: After the last address bit of a read, data-out drives a single 0. Each following serial-clock rising edge drives the next data bit, most significant first. While chip select stays high, the read continues into the next address, wrapping from the top address to 0.
- R5: After reset, programming is locked. Write, erase, erase-all and write-all change nothing and start no busy period until an unlock command is accepted. A lock command restores this state.
- R6: A command cut short by chip select falling before all its opcode, address and data bits are in is discarded.
- R7: An accepted programming command starts when chip select falls. It stays busy for PROG_CYCLES system clocks, or for the larger of PROG_CYCLES and the word count in the case of erase-all and write-all.
- R8: After a programming command is launched, raising chip select shows status on data-out: 0 while busy, 1 once ready. The status display ends at the next start bit.
- R9: Data-out is enabled only while chip select is high and either a read is shifting or status is being shown. Otherwise, including after reset, it is high-impedance.
- R10: Erase sets the addressed word to all ones. Erase-all sets every word to all ones. Write-all stores its data word in every location (both bytes of each 16-bit word in byte mode).
- R11: Start bits sent while programming is busy are ignored, so no command runs and status stays on data-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; bits sampled on its rising edge |
| di | input | 1 | Serial data in |
| org | input | 1 | Word size: 1 = 16-bit words, 0 = bytes; static |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_o; low means high-impedance |

## Verification
The assertions take three things for granted about the inputs: the serial clock is slow compared with the system clock, chip select and data-in change only while the serial clock is low, and org changes only while chip select is low. Given that, the synchronized chip select reliably gates the output enable, and busy always reads as a low status. The bench drives every serial half-period as several system clocks and sets data-in before each rising edge. It switches org only between commands and holds chip select low long enough for the synchronizers to see it. Random commands, addresses and data come from a seeded generator and are scored against a bench-side array model. Directed cases cover the locked state, leading zeros, truncation, wrap-around, byte placement and commands sent while busy.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [2:0] {
      PG_NONE,
      PG_WRITE,
      PG_ERASE,
      PG_ERAL,
      PG_WRAL
   } prog_e;

   typedef enum logic [2:0] {
      C_IDLE,
      C_OPC,
      C_ADR,
      C_DAT,
      C_RD,
      C_DONE
   } cmd_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("mw_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][N-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mw_array.sv
module mw_array
   import mw_pkg::*;
#(
   parameter int AW          = 10,
   parameter int DW          = 16,
   parameter int PROG_CYCLES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          start,
   input  prog_e         op,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_mask,
   input  logic [DW-1:0] wr_data,
   output logic          busy
);
   localparam int DEPTH     = 1 << AW;
   localparam int BULK_LAST = ((DEPTH > PROG_CYCLES) ? DEPTH : PROG_CYCLES) - 1;
   localparam int ONE_LAST  = PROG_CYCLES - 1;
   localparam int CW        = $clog2(BULK_LAST + 1) + 1;

   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("mw_array: PROG_CYCLES must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [CW-1:0] cnt;
   logic          bulk_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] mask_q, val_q;

   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         bulk_q <= 1'b0;
         addr_q <= '0;
         mask_q <= '0;
         val_q  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            cnt    <= '0;
            bulk_q <= (op == PG_ERAL) || (op == PG_WRAL);
            addr_q <= wr_addr;
            mask_q <= wr_mask;
            val_q  <= wr_data;
         end
      end else if (cnt == (bulk_q ? CW'(BULK_LAST) : CW'(ONE_LAST))) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (busy) begin
         if (bulk_q) begin
            if (cnt < CW'(DEPTH)) mem[cnt[AW-1:0]] <= val_q;
         end else if (cnt == '0) begin
            mem[addr_q] <= (mem[addr_q] & ~mask_q) | (val_q & mask_q);
         end
      end
   end
endmodule

// File: rtl/mw_cmd.sv
module mw_cmd
   import mw_pkg::*;
#(
   parameter int WORD_AW = 10,
   parameter int DW      = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_rise,
   input  logic               cs,
   input  logic               di,
   input  logic               org,
   input  logic               busy,
   input  logic [DW-1:0]      rd_data,
   output logic [WORD_AW-1:0] rd_addr,
   output logic               start,
   output prog_e              op,
   output logic [WORD_AW-1:0] wr_addr,
   output logic [DW-1:0]      wr_mask,
   output logic [DW-1:0]      wr_data,
   output logic               do_o,
   output logic               do_oe,
   output logic               wren
);
   localparam int BA  = WORD_AW + 1;
   localparam int HB  = DW / 2;
   localparam int CNW = $clog2(BA + DW + 1);
   localparam logic [DW-1:0] LO_HALF = {{HB{1'b0}}, {HB{1'b1}}};

   cmd_e           state;
   prog_e          pend;
   logic [CNW-1:0] cnt, idx, aw_last, dw_now;
   logic [1:0]     opc, top2;
   logic [BA-1:0]  adr, rd_ba, nadr, nxt_ba;
   logic [DW-1:0]  dat, sr, load_val;
   logic [HB-1:0]  rbyte;
   logic           stat, ld, do_q;

   function automatic logic [WORD_AW-1:0] word_of(input logic [BA-1:0] a, input logic o);
      return o ? a[WORD_AW-1:0] : a[BA-1:1];
   endfunction

   always_comb begin
      aw_last = org ? CNW'(WORD_AW - 1) : CNW'(BA - 1);
      dw_now  = org ? CNW'(DW) : CNW'(HB);
      nadr    = {adr[BA-2:0], di};
      if (org) nadr[BA-1] = 1'b0;
      top2    = org ? nadr[WORD_AW-1 -: 2] : nadr[BA-1 -: 2];
      nxt_ba  = rd_ba + 1'b1;
      if (org) nxt_ba[BA-1] = 1'b0;
      rbyte    = rd_ba[0] ? rd_data[DW-1:HB] : rd_data[HB-1:0];
      load_val = org ? rd_data : {rbyte, {HB{1'b0}}};
   end

   assign rd_addr = word_of(rd_ba, org);
   assign wr_addr = word_of(adr, org);
   assign wr_mask = org ? '1 : (adr[0] ? ~LO_HALF : LO_HALF);
   assign wr_data = (pend == PG_ERASE || pend == PG_ERAL) ? '1 :
                    (org ? dat : {2{dat[HB-1:0]}});
   assign op      = pend;
   assign do_oe   = cs && ((state == C_RD) || stat);
   assign do_o    = stat ? !busy : do_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= C_IDLE;
         pend  <= PG_NONE;
         cnt   <= '0;
         idx   <= '0;
         opc   <= '0;
         adr   <= '0;
         rd_ba <= '0;
         dat   <= '0;
         sr    <= '0;
         stat  <= 1'b0;
         ld    <= 1'b0;
         do_q  <= 1'b0;
         start <= 1'b0;
         wren  <= 1'b0;
      end else begin
         start <= 1'b0;
         ld    <= 1'b0;
         if (ld) sr <= load_val;
         if (!cs) begin
            state <= C_IDLE;
            if (state == C_DONE && pend != PG_NONE && wren) begin
               start <= 1'b1;
               stat  <= 1'b1;
            end
         end else if (sck_rise) begin
            unique case (state)
               C_IDLE: if (di && !busy) begin
                  state <= C_OPC;
                  cnt   <= '0;
                  stat  <= 1'b0;
                  pend  <= PG_NONE;
               end
               C_OPC: begin
                  opc <= {opc[0], di};
                  if (cnt == CNW'(1)) begin
                     state <= C_ADR;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               C_ADR: begin
                  adr <= nadr;
                  if (cnt != aw_last) cnt <= cnt + 1'b1;
                  else begin
                     cnt <= '0;
                     unique case (opc)
                        OP_READ: begin
                           state <= C_RD;
                           rd_ba <= nadr;
                           ld    <= 1'b1;
                           do_q  <= 1'b0;
                           idx   <= dw_now;
                        end
                        OP_WRITE: state <= C_DAT;
                        OP_ERASE: begin
                           state <= C_DONE;
                           pend  <= PG_ERASE;
                        end
                        OP_EXT: begin
                           state <= (top2 == 2'b01) ? C_DAT : C_DONE;
                           if (top2 == 2'b11) wren <= 1'b1;
                           if (top2 == 2'b00) wren <= 1'b0;
                           if (top2 == 2'b10) pend <= PG_ERAL;
                        end
                     endcase
                  end
               end
               C_DAT: begin
                  dat <= {dat[DW-2:0], di};
                  if (cnt == dw_now - 1'b1) begin
                     state <= C_DONE;
                     pend  <= (opc == OP_WRITE) ? PG_WRITE : PG_WRAL;
                  end else cnt <= cnt + 1'b1;
               end
               C_RD: begin
                  do_q <= sr[DW-1];
                  sr   <= sr << 1;
                  if (idx == CNW'(1)) begin
                     rd_ba <= nxt_ba;
                     ld    <= 1'b1;
                     idx   <= dw_now;
                  end else idx <= idx - 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
   import mw_pkg::*;
#(
   parameter int WORD_AW     = 10,
   parameter int DW          = 16,
   parameter int PROG_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sck,
   input  logic di,
   input  logic org,
   output logic do_o,
   output logic do_oe
);
   if (DW % 2 != 0 || DW < 4) begin : g_bad_dw
      $error("mw_eeprom: DW must be even and at least 4");
   end
   if (WORD_AW < 2) begin : g_bad_aw
      $error("mw_eeprom: WORD_AW must be at least 2");
   end

   logic               cs_s, sck_s, di_s, sck_d, sck_rise;
   logic               busy, wren, start;
   prog_e              pop;
   logic [WORD_AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0]      rd_data, wr_mask, wr_data;

   mw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs, sck, di}),
      .q     ({cs_s, sck_s, di_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end
   assign sck_rise = sck_s && !sck_d;

   mw_cmd #(.WORD_AW(WORD_AW), .DW(DW)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_rise (sck_rise),
      .cs       (cs_s),
      .di       (di_s),
      .org      (org),
      .busy     (busy),
      .rd_data  (rd_data),
      .rd_addr  (rd_addr),
      .start    (start),
      .op       (pop),
      .wr_addr  (wr_addr),
      .wr_mask  (wr_mask),
      .wr_data  (wr_data),
      .do_o     (do_o),
      .do_oe    (do_oe),
      .wren     (wren)
   );

   mw_array #(.AW(WORD_AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .start   (start),
      .op      (pop),
      .wr_addr (wr_addr),
      .wr_mask (wr_mask),
      .wr_data (wr_data),
      .busy    (busy)
   );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic do_o,
   input logic do_oe,
   input logic busy,
   input logic wren
);
   // R9: deselected device never drives data-out
   p_hiz_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |-> !do_oe);

   // R8: while programming runs, anything driven is the low busy level
   p_busy_shows_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && do_oe) |-> !do_o);

   // R5: a busy period only begins while programming is unlocked
   p_prog_needs_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wren));

   // R5: locked state straight out of reset
   p_locked_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !wren);

   // R7: programming begins with chip select low
   p_busy_starts_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(!cs_s)) |-> !do_oe);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_s  (cs_s),
   .do_o  (do_o),
   .do_oe (do_oe),
   .busy  (busy),
   .wren  (wren)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;
   localparam int PROG       = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1;
   logic do_o, do_oe;
   int   nchk = 0, nerr = 0;
   logic wren_m = 1'b0;
   logic [15:0] mdl [1024];

   always #(CLK_PERIOD/2) clk = ~clk;

   mw_eeprom #(.PROG_CYCLES(PROG)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di),
      .org(org), .do_o(do_o), .do_oe(do_oe)
   );

   task automatic report();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic int aw();
      return org ? 10 : 11;
   endfunction
   function automatic int dw();
      return org ? 16 : 8;
   endfunction
   function automatic logic [15:0] mget(input int a);
      if (org) return mdl[a & 1023];
      return (a & 1) ? {8'h0, mdl[(a >> 1) & 1023][15:8]} : {8'h0, mdl[(a >> 1) & 1023][7:0]};
   endfunction
   function automatic void mset(input int a, input logic [15:0] v);
      if (org) mdl[a & 1023] = v;
      else if (a & 1) mdl[(a >> 1) & 1023][15:8] = v[7:0];
      else mdl[(a >> 1) & 1023][7:0] = v[7:0];
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic clk_bit(input logic b);
      di = b; sck = 1'b0; tick(HALF);
      sck = 1'b1; tick(HALF);
      sck = 1'b0;
   endtask
   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
   endtask
   task automatic select();
      sck = 1'b0; cs = 1'b1; tick(HALF);
   endtask
   task automatic deselect();
      sck = 1'b0; cs = 1'b0; di = 1'b0; tick(HALF + 2);
   endtask
   task automatic header(input logic [1:0] opc, input int addr);
      select();
      clk_bit(1'b1);
      send(opc, 2);
      send(addr, aw());
   endtask
   task automatic rd_sample(output logic b, output logic oe);
      sck = 1'b0; tick(HALF);
      b = do_o; oe = do_oe;
      sck = 1'b1; tick(HALF);
      sck = 1'b0;
   endtask

   task automatic chk_read(input int addr, input int nw, input string tag);
      logic b, oe;
      logic [15:0] w;
      header(2'b10, addr);
      rd_sample(b, oe);
      check({oe, b}, 2'b10, {tag, " R4 dummy zero"});
      for (int k = 0; k < nw; k++) begin
         int a = (addr + k) & ((1 << aw()) - 1);
         w = '0;
         for (int i = 0; i < dw(); i++) begin
            rd_sample(b, oe);
            w = {w[14:0], b};
         end
         check(w, mget(a), {tag, " R4 read data"});
      end
      deselect();
   endtask

   task automatic wait_ready(input string tag);
      int n = 0;
      select();
      check({do_oe, do_o}, 2'b10, {tag, " R8 busy status low"});
      while (do_o !== 1'b1 && n < 5000) begin
         tick(1);
         n++;
      end
      check({do_oe, do_o}, 2'b11, {tag, " R7 ready after programming"});
      deselect();
   endtask

   task automatic no_status(input string tag);
      select();
      check(do_oe, 1'b0, {tag, " no busy period"});
      deselect();
   endtask

   task automatic finish_prog(input string tag);
      if (wren_m) wait_ready(tag);
      else no_status({tag, " R5 locked"});
   endtask

   task automatic ext(input logic [1:0] sub);
      header(2'b00, int'(sub) << (aw() - 2));
   endtask
   task automatic unlock();
      ext(2'b11); deselect(); wren_m = 1'b1;
   endtask
   task automatic lock();
      ext(2'b00); deselect(); wren_m = 1'b0;
   endtask
   task automatic write(input int a, input logic [15:0] v);
      header(2'b01, a); send(v, dw()); deselect();
      if (wren_m) mset(a, v);
      finish_prog("write R2");
   endtask
   task automatic erase(input int a);
      header(2'b11, a); deselect();
      if (wren_m) mset(a, 16'hFFFF);
      finish_prog("erase R10");
   endtask

   initial begin
      logic b, oe;
      void'($urandom(32'd4242));
      tick(5);
      rst_n = 1'b1;
      tick(3);
      check(do_oe, 1'b0, "R9 reset high-impedance");
      select(); tick(HALF);
      check(do_oe, 1'b0, "R9 selected idle high-impedance");
      deselect();

      // locked after reset
      write(5, 16'h1234);

      // leading zeros before the start bit, then unlock
      select();
      clk_bit(1'b0); clk_bit(1'b0); clk_bit(1'b0);
      clk_bit(1'b1); send(2'b00, 2); send(32'h300, 10);
      deselect(); wren_m = 1'b1;

      // erase-all, checked via busy/ready and reads
      ext(2'b10); deselect();
      for (int i = 0; i < 1024; i++) mdl[i] = 16'hFFFF;
      wait_ready("eral R2 R1");
      chk_read(0, 4, "eral R10");

      lock();
      write(5, 16'h1234);
      chk_read(5, 1, "locked write R5");

      unlock();
      write(5, 16'hA5C3);
      chk_read(4, 3, "sequential");
      chk_read(1023, 2, "wrap");

      // truncated write
      header(2'b01, 7); send(8'h00, 8); deselect();
      no_status("truncated R6");
      chk_read(7, 1, "truncated R6");

      // byte organisation
      org = 1'b0; tick(2);
      write(11, 16'h003C);
      chk_read(10, 2, "byte R3");
      org = 1'b1; tick(2);
      check(mdl[5], 16'h3CC3, "R3 model byte placement");
      chk_read(5, 1, "byte placement R3");

      erase(5);
      chk_read(5, 1, "erase R10");

      // write-all, then a command while busy
      ext(2'b01); send(16'h5AA5, 16); deselect();
      for (int i = 0; i < 1024; i++) mdl[i] = 16'h5AA5;
      header(2'b10, 0);
      rd_sample(b, oe);
      check({oe, b}, 2'b10, "R11 read ignored while busy");
      deselect();
      wait_ready("wral R10");
      chk_read(0, 1, "wral R10");
      chk_read(1023, 1, "wral R10");

      // random mix
      for (int it = 0; it < 40; it++) begin
         int op = int'($urandom % 6);
         org = $urandom % 2;
         tick(2);
         case (op)
            0, 5: write(int'($urandom) & ((1 << aw()) - 1), 16'($urandom));
            1: chk_read(int'($urandom) & ((1 << aw()) - 1), 1 + int'($urandom % 3), "random");
            2: erase(int'($urandom) & ((1 << aw()) - 1));
            3: unlock();
            default: if ($urandom % 2 == 0) lock(); else unlock();
         endcase
      end

      report();
      $finish;
   end
endmodule